// File: doc/BRIEF.md
# Read Latency and Byte Mask Pipeline

This block sits between a burst sequencer and the data pins of a synchronous memory. Each cycle the sequencer may offer one read beat: a valid flag and a 32-bit word made of four byte lanes. The block holds that word back by a programmable number of clocks (1, 2 or 3), so that it reaches the data outputs in the cycle a host controller expects. A per-lane output enable travels with the word. Read data is taken from the array once per beat and presented once.

The same four mask inputs serve both directions, but with different timing. On reads, a mask bit sampled high turns its lane off two clocks later, whatever latency is in use. On writes, the mask gates the lane in the same cycle, and a write beat with every lane masked counts as no operation. High impedance is shown as a cleared per-lane output enable, and any lane that is not enabled drives zeros.

A small controller has two states. PIPE_IDLE means no read beat is in flight. In this state the latency setting is taken from the code input on every clock. PIPE_BUSY means at least one beat is in flight, and the captured latency is frozen. The controller goes from PIPE_IDLE to PIPE_BUSY when a read beat is sampled. It goes from PIPE_BUSY back to PIPE_IDLE once no beat is arriving and no beat remains in the early stages of the delay line. Otherwise each state holds.

Top module: `rd_lat_mask_pipe`

## Requirements
- R1: While reset is asserted and right after it, rd_valid_o, rd_lane_oe_o, rd_data_o, wr_lane_en_o and wr_beat_o are all zero, provided the write and read inputs are low.
- R2: With latency code 3'b001, a read beat sampled at edge n is presented on the outputs from edge n onward, so it is valid at edge n+1.
- R3: With latency code 3'b010, a read beat sampled at edge n is presented from edge n+1, so it is valid at edge n+2.
- R4: With latency code 3'b011, a read beat sampled at edge n is presented from edge n+2, so it is valid at edge n+3.
- R5: Every other latency code (3'b000 and 3'b100 to 3'b111) behaves as latency 3.
- R6: A mask bit sampled high at edge k clears the output enable of its lane for the read word that is valid at edge k+2. A mask bit sampled low leaves that lane enabled.
- R7: Mask bit i controls data bits 8*i+7 down to 8*i, for lanes i = 0 to 3. A disabled lane reads as zero on rd_data_o, and the other lanes carry the array data unchanged.
- R8: During a write cycle, wr_lane_en_o equals the bitwise inverse of the mask in the same cycle. Outside a write cycle it is zero.
- R9: wr_beat_o is high in a write cycle whose mask is not all ones, and low for an all-ones mask.
- R10: A change of the latency code while any read beat is in flight has no effect on that traffic. The new code takes effect for beats issued after the pipeline has drained.
- R11: Read beats issued on consecutive cycles come out on consecutive cycles, in issue order, with their data intact.
- R12: When no read word is being presented, rd_valid_o, rd_lane_oe_o and rd_data_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_beat_i | input | 1 | A read beat from the burst sequencer is present |
| rd_data_i | input | 32 | Array word for the read beat |
| byte_mask_i | input | 4 | Per-lane mask; bit i covers bits 8i+7..8i |
| lat_code_i | input | 3 | Read latency code (1, 2, 3; others mean 3) |
| wr_cycle_i | input | 1 | The current cycle carries a write beat |
| rd_valid_o | output | 1 | A delayed read word is being presented |
| rd_data_o | output | 32 | Presented read word, disabled lanes zeroed |
| rd_lane_oe_o | output | 4 | Per-lane output enable for the read word |
| wr_lane_en_o | output | 4 | Per-lane write enable for the current write beat |
| wr_beat_o | output | 1 | Write beat with at least one lane enabled |

## Verification
The assertions assume that read beats and write cycles do not overlap. They also assume that the latency code is settled at any edge where a beat is sampled while the pipeline is idle. The stimulus changes the code either during long idle gaps or, on purpose, only while earlier beats are still in flight. Where the stimulus allows it, a scoreboard queue pairs every read beat with the edge at which it must appear. The expected lane enables are taken from a recorded history of the mask two edges earlier, so the mask timing is checked apart from the latency actually in use.

// File: rtl/rlm_pkg.sv
package rlm_pkg;

    // Deepest read latency the pipeline supports, in clocks.
    localparam int MAX_LAT   = 3;
    // Clocks from mask sampling to the read word it disables.
    localparam int MASK_LAT  = 2;
    localparam int LAT_SEL_W = $clog2(MAX_LAT);

    typedef enum logic [0:0] {
        PIPE_IDLE = 1'b0,
        PIPE_BUSY = 1'b1
    } pipe_state_e;

    // Map a latency code to the delay-line tap (latency minus one).
    // Codes that are not 1 or 2 select the deepest tap.
    function automatic logic [LAT_SEL_W-1:0] lat_tap(input logic [2:0] code);
        logic [LAT_SEL_W-1:0] tap;
        case (code)
            3'd1:    tap = LAT_SEL_W'(0);
            3'd2:    tap = LAT_SEL_W'(1);
            default: tap = LAT_SEL_W'(MAX_LAT - 1);
        endcase
        return tap;
    endfunction

endpackage

// File: rtl/rlm_delay_line.sv
module rlm_delay_line #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 3,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              beat_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [SEL_W-1:0]  sel_i,
    output logic [DEPTH-1:0]  stage_v_o,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o
);

    logic [DEPTH-1:0]  v_q;
    logic [DATA_W-1:0] d_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    v_q[g] <= 1'b0;
                    d_q[g] <= '0;
                end else begin
                    v_q[g] <= beat_i;
                    d_q[g] <= beat_i ? data_i : '0;
                end
            end
        end else begin : g_tail
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    v_q[g] <= 1'b0;
                    d_q[g] <= '0;
                end else begin
                    v_q[g] <= v_q[g-1];
                    d_q[g] <= d_q[g-1];
                end
            end
        end
    end

    assign stage_v_o = v_q;

    always_comb begin
        valid_o = 1'b0;
        data_o  = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (sel_i == SEL_W'(i)) begin
                valid_o = v_q[i];
                data_o  = d_q[i];
            end
        end
    end

endmodule

// File: rtl/rlm_mask_stage.sv
module rlm_mask_stage #(
    parameter int LANES    = 4,
    parameter int MASK_LAT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] mask_i,
    input  logic             wr_cycle_i,
    output logic [LANES-1:0] rd_mask_o,
    output logic [LANES-1:0] wr_en_o,
    output logic             wr_beat_o
);

    // Read side: mask sampled at edge k reaches the word valid at k+MASK_LAT.
    // The word shown after edge k+MASK_LAT-1 needs MASK_LAT-1 registers
    // after the sampling register, hence MASK_LAT registers in all.
    logic [LANES-1:0] m_q [MASK_LAT];

    for (genvar g = 0; g < MASK_LAT; g++) begin : g_mstage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) m_q[g] <= '0;
                else        m_q[g] <= mask_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) m_q[g] <= '0;
                else        m_q[g] <= m_q[g-1];
            end
        end
    end

    assign rd_mask_o = m_q[MASK_LAT-1];

    // Write side: same-cycle lane gating, no register.
    always_comb begin
        wr_en_o   = wr_cycle_i ? ~mask_i : '0;
        wr_beat_o = wr_cycle_i && (mask_i != {LANES{1'b1}});
    end

endmodule

// File: rtl/rlm_ctrl.sv
module rlm_ctrl
    import rlm_pkg::*;
#(
    parameter int DEPTH = 3,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat_i,
    input  logic [2:0]       code_i,
    input  logic [DEPTH-1:0] stage_v_i,
    output logic             busy_o,
    output logic [SEL_W-1:0] sel_o
);

    pipe_state_e      state_q, state_d;
    logic [SEL_W-1:0] sel_q;
    logic             drained;

    // After this edge, no beat will sit in any stage that can still move
    // forward into a tap other than the last one.
    assign drained = !beat_i && (stage_v_i[DEPTH-2:0] == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PIPE_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        busy_o  = 1'b0;
        unique case (state_q)
            PIPE_IDLE: begin
                busy_o = 1'b0;
                if (beat_i) state_d = PIPE_BUSY;
            end
            PIPE_BUSY: begin
                busy_o = 1'b1;
                if (drained) state_d = PIPE_IDLE;
            end
            default: state_d = PIPE_IDLE;
        endcase
    end

    // Latency is captured only while nothing is in flight.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    sel_q <= SEL_W'(DEPTH - 1);
        else if (state_q == PIPE_IDLE) sel_q <= SEL_W'(lat_tap(code_i));
    end

    assign sel_o = sel_q;

endmodule

// File: rtl/rd_lat_mask_pipe.sv
module rd_lat_mask_pipe
    import rlm_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rd_beat_i,
    input  logic [LANES*LANE_W-1:0] rd_data_i,
    input  logic [LANES-1:0]        byte_mask_i,
    input  logic [2:0]              lat_code_i,
    input  logic                    wr_cycle_i,
    output logic                    rd_valid_o,
    output logic [LANES*LANE_W-1:0] rd_data_o,
    output logic [LANES-1:0]        rd_lane_oe_o,
    output logic [LANES-1:0]        wr_lane_en_o,
    output logic                    wr_beat_o
);

    localparam int DATA_W = LANES * LANE_W;
    localparam int DEPTH  = MAX_LAT;
    localparam int SEL_W  = LAT_SEL_W;

    logic [DEPTH-1:0]  stage_v;
    logic [SEL_W-1:0]  lat_sel;
    logic              busy;
    logic              tap_valid;
    logic [DATA_W-1:0] tap_data;
    logic [LANES-1:0]  rd_mask;

    rlm_ctrl #(
        .DEPTH (DEPTH),
        .SEL_W (SEL_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .beat_i    (rd_beat_i),
        .code_i    (lat_code_i),
        .stage_v_i (stage_v),
        .busy_o    (busy),
        .sel_o     (lat_sel)
    );

    rlm_delay_line #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH),
        .SEL_W  (SEL_W)
    ) u_delay (
        .clk       (clk),
        .rst_n     (rst_n),
        .beat_i    (rd_beat_i),
        .data_i    (rd_data_i),
        .sel_i     (lat_sel),
        .stage_v_o (stage_v),
        .valid_o   (tap_valid),
        .data_o    (tap_data)
    );

    rlm_mask_stage #(
        .LANES    (LANES),
        .MASK_LAT (MASK_LAT)
    ) u_mask (
        .clk        (clk),
        .rst_n      (rst_n),
        .mask_i     (byte_mask_i),
        .wr_cycle_i (wr_cycle_i),
        .rd_mask_o  (rd_mask),
        .wr_en_o    (wr_lane_en_o),
        .wr_beat_o  (wr_beat_o)
    );

    assign rd_valid_o   = tap_valid;
    assign rd_lane_oe_o = {LANES{tap_valid}} & ~rd_mask;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign rd_data_o[l*LANE_W +: LANE_W] =
            rd_lane_oe_o[l] ? tap_data[l*LANE_W +: LANE_W] : '0;
    end

endmodule

// File: rtl/rd_lat_mask_chk.sv
module rd_lat_mask_chk #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    parameter int SEL_W  = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    rd_beat_i,
    input logic [LANES-1:0]        byte_mask_i,
    input logic [2:0]              lat_code_i,
    input logic                    wr_cycle_i,
    input logic                    rd_valid_o,
    input logic [LANES*LANE_W-1:0] rd_data_o,
    input logic [LANES-1:0]        rd_lane_oe_o,
    input logic [LANES-1:0]        wr_lane_en_o,
    input logic                    wr_beat_o,
    input logic                    busy,
    input logic [SEL_W-1:0]        lat_sel
);

    logic [1:0] cyc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cyc <= '0;
        else if (cyc != 2'd3)  cyc <= cyc + 2'd1;
    end

    // R12: nothing leaks out when no word is presented
    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid_o |-> (rd_lane_oe_o == '0 && rd_data_o == '0));

    // R6: read mask acts two edges after it is sampled
    a_r6_mask_two_late: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 2'd2 && rd_valid_o) |-> rd_lane_oe_o == ~$past(byte_mask_i, 2));

    // R2: latency 1 from idle shows the word right after the sampling edge
    a_r2_lat_one: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && lat_code_i == 3'd1 && rd_beat_i) |=> rd_valid_o);

    // R8: no write enables outside write cycles
    a_r8_wr_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_cycle_i |-> wr_lane_en_o == '0);

    // R9: an accepted write beat always enables some lane
    a_r9_wr_nop: assert property (@(posedge clk) disable iff (!rst_n)
        wr_beat_o |-> wr_lane_en_o != '0);

    // R10: captured latency frozen while beats are in flight
    a_r10_lat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 2'd1 && $past(busy)) |-> $stable(lat_sel));

endmodule

bind rd_lat_mask_pipe rd_lat_mask_chk #(
    .LANES  (LANES),
    .LANE_W (LANE_W),
    .SEL_W  (SEL_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_beat_i    (rd_beat_i),
    .byte_mask_i  (byte_mask_i),
    .lat_code_i   (lat_code_i),
    .wr_cycle_i   (wr_cycle_i),
    .rd_valid_o   (rd_valid_o),
    .rd_data_o    (rd_data_o),
    .rd_lane_oe_o (rd_lane_oe_o),
    .wr_lane_en_o (wr_lane_en_o),
    .wr_beat_o    (wr_beat_o),
    .busy         (busy),
    .lat_sel      (lat_sel)
);

// File: tb/rd_lat_mask_pipe_bench.sv
module rd_lat_mask_pipe_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_beat_i = 1'b0;
    logic [31:0] rd_data_i = '0;
    logic [3:0]  byte_mask_i = '0;
    logic [2:0]  lat_code_i = 3'd1;
    logic        wr_cycle_i = 1'b0;
    logic        rd_valid_o;
    logic [31:0] rd_data_o;
    logic [3:0]  rd_lane_oe_o;
    logic [3:0]  wr_lane_en_o;
    logic        wr_beat_o;

    rd_lat_mask_pipe u_rd_lat_mask_pipe (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_beat_i    (rd_beat_i),
        .rd_data_i    (rd_data_i),
        .byte_mask_i  (byte_mask_i),
        .lat_code_i   (lat_code_i),
        .wr_cycle_i   (wr_cycle_i),
        .rd_valid_o   (rd_valid_o),
        .rd_data_o    (rd_data_o),
        .rd_lane_oe_o (rd_lane_oe_o),
        .wr_lane_en_o (wr_lane_en_o),
        .wr_beat_o    (wr_beat_o)
    );

    always #5 clk = ~clk;

    typedef struct {
        int          due;
        logic [31:0] data;
        string       tag;
    } exp_item_t;

    exp_item_t   sb[$];
    logic [3:0]  mask_hist [0:4095];
    int          ec = 0;
    int          n_checks = 0;
    int          n_fail = 0;
    bit          mon_on = 1'b0;
    bit          done = 1'b0;
    logic [2:0]  cur_code = 3'd1;
    logic [31:0] lfsr = 32'h1234_5678;

    always @(posedge clk) ec <= ec + 1;

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h (edge %0d)", tag, act, exp, ec);
        end
    endtask

    function automatic logic [31:0] lane_apply(input logic [31:0] d, input logic [3:0] oe);
        logic [31:0] r = '0;
        for (int i = 0; i < 4; i++)
            if (oe[i]) r[8*i +: 8] = d[8*i +: 8];
        return r;
    endfunction

    // Driver: one cycle of stimulus, pushes the expected read word.
    task automatic step(input bit beat, input logic [31:0] data, input logic [3:0] mask,
                        input bit wr, input int lat, input string tag);
        exp_item_t it;
        @(negedge clk);
        rd_beat_i   = beat;
        rd_data_i   = data;
        byte_mask_i = mask;
        wr_cycle_i  = wr;
        lat_code_i  = cur_code;
        mask_hist[(ec + 1) % 4096] = mask;
        if (beat) begin
            it.due  = ec + lat;
            it.data = data;
            it.tag  = tag;
            sb.push_back(it);
        end
        #1;
        if (wr) begin
            check(wr_lane_en_o == ~mask, "R8 write lane enables",
                  64'(wr_lane_en_o), 64'(~mask));
            check(wr_beat_o == (mask != 4'hF), "R9 write beat",
                  64'(wr_beat_o), 64'(mask != 4'hF));
        end else begin
            check(wr_lane_en_o == 4'h0 && wr_beat_o == 1'b0, "R8 no write",
                  64'({wr_beat_o, wr_lane_en_o}), 64'h0);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 32'h0, 4'h0, 1'b0, 1, "R12");
    endtask

    function automatic logic [31:0] next_rand();
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >> 17);
        lfsr = lfsr ^ (lfsr << 5);
        return lfsr;
    endfunction

    // Monitor: compares presented words against the scoreboard.
    always @(negedge clk) begin
        if (mon_on) begin
            if (sb.size() > 0 && sb[0].due == ec) begin
                exp_item_t it;
                logic [3:0]  eoe;
                logic [31:0] ed;
                it  = sb.pop_front();
                eoe = ~mask_hist[(ec - 1) % 4096];
                ed  = lane_apply(it.data, eoe);
                check(rd_valid_o == 1'b1 && rd_lane_oe_o == eoe && rd_data_o == ed,
                      it.tag, {27'h0, rd_valid_o, rd_lane_oe_o, rd_data_o},
                      {27'h0, 1'b1, eoe, ed});
            end else begin
                check(rd_valid_o == 1'b0 && rd_lane_oe_o == 4'h0 && rd_data_o == 32'h0,
                      "R12 quiet output", {27'h0, rd_valid_o, rd_lane_oe_o, rd_data_o}, 64'h0);
            end
        end
    end

    initial begin
        for (int i = 0; i < 4096; i++) mask_hist[i] = 4'h0;
        repeat (3) @(negedge clk);
        check(rd_valid_o == 1'b0 && rd_lane_oe_o == 4'h0 && rd_data_o == 32'h0 &&
              wr_lane_en_o == 4'h0 && wr_beat_o == 1'b0, "R1 reset state",
              {22'h0, rd_valid_o, rd_lane_oe_o, wr_beat_o, wr_lane_en_o, rd_data_o}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(rd_valid_o == 1'b0 && wr_beat_o == 1'b0, "R1 after reset",
              64'({rd_valid_o, wr_beat_o}), 64'h0);
        mon_on = 1'b1;

        // R2: latency 1
        cur_code = 3'd1;
        idle(4);
        step(1'b1, 32'hA1B2_C3D4, 4'h0, 1'b0, 1, "R2 latency one");
        idle(6);

        // R3: latency 2
        cur_code = 3'd2;
        idle(4);
        step(1'b1, 32'h1122_3344, 4'h0, 1'b0, 2, "R3 latency two");
        idle(6);

        // R4: latency 3
        cur_code = 3'd3;
        idle(4);
        step(1'b1, 32'h5566_7788, 4'h0, 1'b0, 3, "R4 latency three");
        idle(6);

        // R5: reserved codes behave as latency 3
        cur_code = 3'd0;
        idle(4);
        step(1'b1, 32'hDEAD_0000, 4'h0, 1'b0, 3, "R5 reserved code 0");
        idle(6);
        cur_code = 3'd7;
        idle(4);
        step(1'b1, 32'hBEEF_0007, 4'h0, 1'b0, 3, "R5 reserved code 7");
        idle(6);
        cur_code = 3'd4;
        idle(4);
        step(1'b1, 32'hCAFE_0004, 4'h0, 1'b0, 3, "R5 reserved code 4");
        idle(6);

        // R6/R7: single-lane masks at every latency, mask issued ahead and during
        for (int c = 1; c <= 3; c++) begin
            cur_code = 3'(c);
            idle(4);
            for (int l = 0; l < 4; l++) begin
                step(1'b0, 32'h0, 4'(1 << l), 1'b0, c, "R7");
                step(1'b1, 32'hF0E1_D2C3 ^ 32'(l), 4'(1 << l), 1'b0, c, "R7 lane mapping");
                step(1'b0, 32'h0, 4'(1 << l), 1'b0, c, "R7");
                idle(4);
            end
        end

        // R6/R11: back-to-back streams with changing masks at each latency
        for (int c = 1; c <= 3; c++) begin
            cur_code = 3'(c);
            idle(5);
            for (int b = 0; b < 10; b++) begin
                logic [31:0] r;
                r = next_rand();
                step(1'b1, r, r[31:28], 1'b0, c, "R6 R11 streamed read mask");
            end
            idle(6);
        end

        // R8/R9: write beats, including all-masked no-op
        step(1'b0, 32'h0, 4'h0, 1'b1, 1, "R8");
        step(1'b0, 32'h0, 4'h5, 1'b1, 1, "R8");
        step(1'b0, 32'h0, 4'hE, 1'b1, 1, "R8");
        step(1'b0, 32'h0, 4'hF, 1'b1, 1, "R9");
        step(1'b0, 32'h0, 4'h7, 1'b1, 1, "R9");
        step(1'b0, 32'h0, 4'hF, 1'b0, 1, "R8");
        idle(6);

        // R10: latency code changes while beats are in flight
        cur_code = 3'd1;
        idle(4);
        step(1'b1, 32'h0000_0A01, 4'h0, 1'b0, 1, "R10 before change");
        step(1'b1, 32'h0000_0A02, 4'h0, 1'b0, 1, "R10 before change");
        cur_code = 3'd3;
        step(1'b1, 32'h0000_0A03, 4'h0, 1'b0, 1, "R10 change ignored while busy");
        step(1'b1, 32'h0000_0A04, 4'h0, 1'b0, 1, "R10 change ignored while busy");
        idle(6);
        step(1'b1, 32'h0000_0A05, 4'h0, 1'b0, 3, "R10 new latency after drain");
        idle(6);
        cur_code = 3'd2;
        idle(4);
        step(1'b1, 32'h0000_0B01, 4'h0, 1'b0, 2, "R10 latency two");
        cur_code = 3'd1;
        step(1'b1, 32'h0000_0B02, 4'h0, 1'b0, 2, "R10 change ignored while busy");
        idle(6);
        step(1'b1, 32'h0000_0B03, 4'h0, 1'b0, 1, "R10 new latency after drain");
        idle(8);

        check(sb.size() == 0, "R11 all beats delivered", 64'(sb.size()), 64'h0);
        mon_on = 1'b0;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule